// File: doc/BRIEF.md
# Ten-Port Crossbar with Per-Target Round-Robin Arbitration

This block connects ten 32-bit request ports to eight target ports. Each request port carries an address, a write flag and write data under a valid/ready handshake. The crossbar decodes the address to one target and checks it against a fixed table of the targets that this request port may reach. If the check passes, the request goes to that target's arbiter. Each target has its own round-robin arbiter, so requests aimed at different targets are served in the same cycle.

A request that the table refuses, or whose address hits no mapped region, never reaches a target. The crossbar answers it one cycle later with an error response. A grant, once made, holds until the target signals completion. The target's round-robin pointer then moves to the port after the one just served. The block is meant to sit between a CPU's three bus ports, several DMA engines and the chip's memories and peripheral spaces.

Top module: `mlx_crossbar`

## Requirements
- R1: While reset is active, and after it, with no request presented, every `t_valid`, `m_ready` and `m_err` bit is 0. The reset release reaches the logic through a two-stage synchronizer.
- R2: The address map (inclusive ranges) decodes as follows. Flash 0x0800_0000–0x080F_FFFF goes to target 0 or 1 (see R11). SRAM1 0x2000_0000–0x2001_BFFF goes to target 2. SRAM2 0x2001_C000–0x2001_FFFF goes to target 3. SRAM3 0x2002_0000–0x2002_FFFF goes to target 4. Peripheral space A 0x4002_0000–0x4007_FFFF goes to target 5. Peripheral space B 0x5000_0000–0x5FFF_FFFF goes to target 6. External memory 0x6000_0000–0x9FFF_FFFF goes to target 7.
- R3: The reach table gives, for each request port, the targets it may use. Port 0 (CPU fetch) may use targets 0, 2, 3, 4 and 7. Port 1 (CPU data) may use targets 1 and 7. Ports 2 (CPU system) and 5 (DMA peripheral side) may use targets 2 to 7. Ports 3 and 4 (DMA memory sides) may use targets 2, 3, 4 and 7. Ports 6 to 9 (network, USB, display and 2D-graphics DMA) may use targets 1, 2, 3, 4 and 7.
- R4: Some requests are refused: an unmapped address (this includes the core-coupled RAM window at 0x1000_0000) or a target outside the port's reach set. A refused request presented in cycle N gives `m_ready`=1 and `m_err`=1 in cycle N+1, for one cycle. It never raises any `t_valid`.
- R5: An accepted request presented in cycle N to an idle target that grants it drives that target's `t_valid`, `t_addr`, `t_write` and `t_wdata` from cycle N+1.
- R6: When a target raises `t_ready` while granted, its granted port sees `m_ready`=1, `m_err`=0 and `m_rdata`=`t_rdata` in that same cycle. The grant is released at the next edge.
- R7: A grant stays with the same port, with `t_valid` held, for as long as `t_ready` is low. Other ports aimed at that target wait.
- R8: When a target is idle, its grant goes to the first requesting port found by searching upward from the pointer, wrapping from 9 to 0. After a completion, the pointer becomes the served port's index plus one, modulo 10.
- R9: Ports aimed at different targets are granted in the same cycle, with no serialization between them.
- R10: After reset every pointer is at port 0. Simultaneous first requests to one target therefore go to the lowest-indexed accepted port.
- R11: A flash-range address decodes to target 0 for port 0 and to target 1 for every other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_valid | input | 10 | Request present, per port |
| m_ready | output | 10 | Transfer finished (data or error), per port |
| m_write | input | 10 | Write flag, per port |
| m_addr | input | 10 × 32 | Byte address, per port |
| m_wdata | input | 10 × 32 | Write data, per port |
| m_rdata | output | 10 × 32 | Read data, valid with m_ready, per port |
| m_err | output | 10 | Error response, valid with m_ready, per port |
| t_valid | output | 8 | Granted transfer present, per target |
| t_ready | input | 8 | Target finishes the transfer, per target |
| t_write | output | 8 | Routed write flag, per target |
| t_addr | output | 8 × 32 | Routed address, per target |
| t_wdata | output | 8 × 32 | Routed write data, per target |
| t_rdata | input | 8 × 32 | Read data from target, per target |

## Verification
The hardest case to reach from the ports is a target whose grant is held for several cycles while nearly every port queues behind it. The case must also include a refused request mixed into the same cycle and a pointer that has to skip that refused port. A directed phase starts straight out of reset with all ten ports aimed at SRAM1 and the target held not-ready. That phase checks the reset-pointer winner, the held grant, the error for the CPU data port and the skip to port 2. A long random phase follows, with random target readiness and random addresses including region edges and unmapped holes. It drives the pointers through many wrap-arounds, and the bench compares every cycle against a behavioural model.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

  localparam int unsigned NUM_MST   = 10;
  localparam int unsigned NUM_TGT   = 8;
  localparam int unsigned MST_IDX_W = $clog2(NUM_MST);
  localparam int unsigned TGT_IDX_W = $clog2(NUM_TGT);

  typedef enum logic [TGT_IDX_W-1:0] {
    TG_FLASH_I,
    TG_FLASH_D,
    TG_SRAM1,
    TG_SRAM2,
    TG_SRAM3,
    TG_PERIPH_A,
    TG_PERIPH_B,
    TG_EXTMEM
  } tgt_e;

  localparam int unsigned MST_CPU_FETCH = 0;
  localparam int unsigned MST_CPU_DATA  = 1;
  localparam int unsigned MST_CPU_SYS   = 2;
  localparam int unsigned MST_DMA_A_MEM = 3;
  localparam int unsigned MST_DMA_B_MEM = 4;
  localparam int unsigned MST_DMA_B_PER = 5;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
  } span_t;

  localparam span_t SPAN_FLASH  = '{lo: 32'h0800_0000, hi: 32'h080F_FFFF};
  localparam span_t SPAN_SRAM1  = '{lo: 32'h2000_0000, hi: 32'h2001_BFFF};
  localparam span_t SPAN_SRAM2  = '{lo: 32'h2001_C000, hi: 32'h2001_FFFF};
  localparam span_t SPAN_SRAM3  = '{lo: 32'h2002_0000, hi: 32'h2002_FFFF};
  localparam span_t SPAN_PERA   = '{lo: 32'h4002_0000, hi: 32'h4007_FFFF};
  localparam span_t SPAN_PERB   = '{lo: 32'h5000_0000, hi: 32'h5FFF_FFFF};
  localparam span_t SPAN_EXTMEM = '{lo: 32'h6000_0000, hi: 32'h9FFF_FFFF};

  function automatic logic in_span(input logic [31:0] a, input span_t s);
    return (a >= s.lo) && (a <= s.hi);
  endfunction

  // Bit t set: port may use target t. Bit order is target index 7..0.
  function automatic logic [NUM_TGT-1:0] reach_of(input int unsigned mst);
    case (mst)
      MST_CPU_FETCH:                reach_of = 8'b1001_1101;
      MST_CPU_DATA:                 reach_of = 8'b1000_0010;
      MST_CPU_SYS, MST_DMA_B_PER:   reach_of = 8'b1111_1100;
      MST_DMA_A_MEM, MST_DMA_B_MEM: reach_of = 8'b1001_1100;
      default:                      reach_of = 8'b1001_1110;
    endcase
  endfunction

endpackage

// File: rtl/mlx_rst_sync.sv
module mlx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mlx_decode.sv
module mlx_decode
  import mlx_pkg::*;
#(
  parameter int unsigned MST_ID = 0,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [TGT_IDX_W-1:0] tgt_o,
  output logic                 legal_o
);

  localparam logic [NUM_TGT-1:0] REACH = reach_of(MST_ID);
  localparam tgt_e FLASH_PORT = (MST_ID == MST_CPU_FETCH) ? TG_FLASH_I : TG_FLASH_D;

  logic [31:0] a32;
  logic        hit;
  tgt_e        sel;

  assign a32 = 32'(addr_i);

  always_comb begin
    hit = 1'b1;
    sel = TG_EXTMEM;
    if      (in_span(a32, SPAN_FLASH))  sel = FLASH_PORT;
    else if (in_span(a32, SPAN_SRAM1))  sel = TG_SRAM1;
    else if (in_span(a32, SPAN_SRAM2))  sel = TG_SRAM2;
    else if (in_span(a32, SPAN_SRAM3))  sel = TG_SRAM3;
    else if (in_span(a32, SPAN_PERA))   sel = TG_PERIPH_A;
    else if (in_span(a32, SPAN_PERB))   sel = TG_PERIPH_B;
    else if (in_span(a32, SPAN_EXTMEM)) sel = TG_EXTMEM;
    else                                hit = 1'b0;
  end

  assign tgt_o   = sel;
  assign legal_o = hit & REACH[sel];

endmodule

// File: rtl/mlx_rr_arb.sv
module mlx_rr_arb #(
  parameter  int unsigned NREQ = 10,
  localparam int unsigned IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic            ready_i,
  output logic            busy_o,
  output logic [IW-1:0]   idx_o,
  output logic [NREQ-1:0] gnt_o
);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] pick;
  logic          found;
  logic          upd_en;
  int            cand;

  // Search upward from the pointer, wrapping at NREQ.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    cand  = 0;
    for (int k = 0; k < int'(NREQ); k++) begin
      cand = (int'(ptr_q) + k) % int'(NREQ);
      if (!found && req_i[cand]) begin
        found = 1'b1;
        pick  = IW'(cand);
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    ptr_d  = ptr_q;
    if (busy_q) begin
      if (ready_i) begin
        busy_d = 1'b0;
        ptr_d  = (idx_q == IW'(NREQ - 1)) ? '0 : idx_q + 1'b1;
      end
    end else if (found) begin
      busy_d = 1'b1;
      idx_d  = pick;
    end
  end

  assign upd_en = busy_q ? ready_i : found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      ptr_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      ptr_q  <= ptr_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign gnt_o  = busy_q ? (NREQ'(1) << idx_q) : '0;

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ready_i |=> busy_q && $stable(idx_q)); // R7

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && (|req_i) |=> busy_q && (|(gnt_o & $past(req_i)))); // R5

  AST_RELEASE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ready_i |=> !busy_q); // R6

endmodule

// File: rtl/mlx_crossbar.sv
module mlx_crossbar
  import mlx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_MST-1:0]               m_valid,
  output logic [NUM_MST-1:0]               m_ready,
  input  logic [NUM_MST-1:0]               m_write,
  input  logic [NUM_MST-1:0][ADDR_W-1:0]   m_addr,
  input  logic [NUM_MST-1:0][DATA_W-1:0]   m_wdata,
  output logic [NUM_MST-1:0][DATA_W-1:0]   m_rdata,
  output logic [NUM_MST-1:0]               m_err,
  output logic [NUM_TGT-1:0]               t_valid,
  input  logic [NUM_TGT-1:0]               t_ready,
  output logic [NUM_TGT-1:0]               t_write,
  output logic [NUM_TGT-1:0][ADDR_W-1:0]   t_addr,
  output logic [NUM_TGT-1:0][DATA_W-1:0]   t_wdata,
  input  logic [NUM_TGT-1:0][DATA_W-1:0]   t_rdata
);

  logic                               rst_sync_n;
  logic [NUM_MST-1:0][TGT_IDX_W-1:0]  tsel;
  logic [NUM_MST-1:0]                 legal;
  logic [NUM_MST-1:0]                 err_q, err_d;
  logic                               err_en;
  logic [NUM_TGT-1:0][NUM_MST-1:0]    req_tm;
  logic [NUM_TGT-1:0][NUM_MST-1:0]    gnt_tm;
  logic [NUM_TGT-1:0]                 busy;
  logic [NUM_TGT-1:0][MST_IDX_W-1:0]  gidx;

  mlx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-port decode, refusal flag and response return path.
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    localparam logic [NUM_TGT-1:0] RM = reach_of(m);

    logic              done_m;
    logic              any_gnt;
    logic [DATA_W-1:0] rd_m;

    mlx_decode #(.MST_ID(m), .ADDR_W(ADDR_W)) i_decode (
      .addr_i  (m_addr[m]),
      .tgt_o   (tsel[m]),
      .legal_o (legal[m])
    );

    always_comb begin
      done_m  = 1'b0;
      any_gnt = 1'b0;
      rd_m    = '0;
      for (int t = 0; t < int'(NUM_TGT); t++) begin
        any_gnt = any_gnt | gnt_tm[t][m];
        if (gnt_tm[t][m] && t_ready[t]) begin
          done_m = 1'b1;
          rd_m   = t_rdata[t];
        end
      end
    end

    assign err_d[m]   = m_valid[m] & ~legal[m] & ~err_q[m];
    assign m_ready[m] = done_m | err_q[m];
    assign m_err[m]   = err_q[m];
    assign m_rdata[m] = rd_m;

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      err_q[m] |=> !err_q[m]); // R4

    AST_REFUSED_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_sync_n)
      m_err[m] |-> !any_gnt); // R4

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_reach
      AST_REACH_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
        gnt_tm[t][m] |-> RM[t]); // R3
    end
  end

  assign err_en = |(err_q | err_d);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  err_q <= '0;
    else if (err_en)  err_q <= err_d;
  end

  // Per-target request gather, arbitration and forward routing.
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    for (genvar m = 0; m < NUM_MST; m++) begin : g_req
      assign req_tm[t][m] = m_valid[m] & legal[m] & (tsel[m] == TGT_IDX_W'(t));
    end

    mlx_rr_arb #(.NREQ(NUM_MST)) i_arb (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .req_i   (req_tm[t]),
      .ready_i (t_ready[t]),
      .busy_o  (busy[t]),
      .idx_o   (gidx[t]),
      .gnt_o   (gnt_tm[t])
    );

    assign t_valid[t] = busy[t];
    assign t_write[t] = busy[t] & m_write[gidx[t]];
    assign t_addr[t]  = busy[t] ? m_addr[gidx[t]]  : '0;
    assign t_wdata[t] = busy[t] ? m_wdata[gidx[t]] : '0;
  end

endmodule

// File: tb/test_mlx_crossbar.sv
module test_mlx_crossbar;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 10;
  localparam int NT = 8;

  logic clk;
  logic rst_n;
  logic [NM-1:0]         mv, mw;
  logic [NM-1:0][31:0]   maddr, mwd;
  logic [NM-1:0]         m_ready, m_err;
  logic [NM-1:0][31:0]   m_rdata;
  logic [NT-1:0]         tr;
  logic [NT-1:0][31:0]   trd;
  logic [NT-1:0]         t_valid, t_write;
  logic [NT-1:0][31:0]   t_addr, t_wdata;

  int nchk = 0;
  int nfail = 0;

  // Reference model state
  int g[NT];
  int p[NT];
  bit merr[NM];

  // Outputs captured at the last compare
  logic [NT-1:0]       obs_tv;
  logic [NT-1:0][31:0] obs_taddr;
  logic [NM-1:0]       obs_mr, obs_me;

  mlx_crossbar i_mlx_crossbar (
    .clk(clk), .rst_n(rst_n),
    .m_valid(mv), .m_ready(m_ready), .m_write(mw), .m_addr(maddr),
    .m_wdata(mwd), .m_rdata(m_rdata), .m_err(m_err),
    .t_valid(t_valid), .t_ready(tr), .t_write(t_write), .t_addr(t_addr),
    .t_wdata(t_wdata), .t_rdata(trd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Target index the requirements give, or -1 for a refused request.
  function automatic int ref_tgt(int m, logic [31:0] a);
    int t;
    bit ok;
    t = -1;
    if      (a >= 32'h0800_0000 && a <= 32'h080F_FFFF) t = (m == 0) ? 0 : 1;
    else if (a >= 32'h2000_0000 && a <= 32'h2001_BFFF) t = 2;
    else if (a >= 32'h2001_C000 && a <= 32'h2001_FFFF) t = 3;
    else if (a >= 32'h2002_0000 && a <= 32'h2002_FFFF) t = 4;
    else if (a >= 32'h4002_0000 && a <= 32'h4007_FFFF) t = 5;
    else if (a >= 32'h5000_0000 && a <= 32'h5FFF_FFFF) t = 6;
    else if (a >= 32'h6000_0000 && a <= 32'h9FFF_FFFF) t = 7;
    if (t < 0) return -1;
    case (m)
      0:       ok = t inside {0, 2, 3, 4, 7};
      1:       ok = t inside {1, 7};
      2, 5:    ok = t inside {[2:7]};
      3, 4:    ok = t inside {2, 3, 4, 7};
      default: ok = t inside {1, 2, 3, 4, 7};
    endcase
    return ok ? t : -1;
  endfunction

  // One clock cycle: entered just after a falling edge with inputs set.
  task automatic step();
    int  ng[NT];
    int  np[NT];
    bit  ne[NM];
    bit  fin[NM];
    #1;
    for (int t = 0; t < NT; t++) begin
      chk("R7", "t_valid", 32'(t_valid[t]), 32'(g[t] >= 0));
      if (g[t] >= 0) begin
        chk("R5", "t_addr",  t_addr[t],  maddr[g[t]]);
        chk("R5", "t_write", 32'(t_write[t]), 32'(mw[g[t]]));
        chk("R5", "t_wdata", t_wdata[t], mwd[g[t]]);
      end
    end
    for (int m = 0; m < NM; m++) begin
      int src;
      src = -1;
      for (int t = 0; t < NT; t++) if (g[t] == m && tr[t]) src = t;
      fin[m] = merr[m] || (src >= 0);
      chk("R6", "m_ready", 32'(m_ready[m]), 32'(fin[m]));
      chk("R4", "m_err",   32'(m_err[m]),   32'(merr[m]));
      if (src >= 0) chk("R6", "m_rdata", m_rdata[m], trd[src]);
    end
    obs_tv = t_valid; obs_taddr = t_addr; obs_mr = m_ready; obs_me = m_err;
    for (int t = 0; t < NT; t++) begin
      ng[t] = g[t];
      np[t] = p[t];
      if (g[t] >= 0) begin
        if (tr[t]) begin
          np[t] = (g[t] + 1) % NM;
          ng[t] = -1;
        end
      end else begin
        for (int k = 0; k < NM; k++) begin
          int i;
          i = (p[t] + k) % NM;
          if (ng[t] < 0 && mv[i] && ref_tgt(i, maddr[i]) == t) ng[t] = i;
        end
      end
    end
    for (int m = 0; m < NM; m++)
      ne[m] = mv[m] && (ref_tgt(m, maddr[m]) < 0) && !merr[m];
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin g[t] = ng[t]; p[t] = np[t]; end
    for (int m = 0; m < NM; m++) merr[m] = ne[m];
    @(negedge clk);
    for (int m = 0; m < NM; m++) if (fin[m]) mv[m] = 1'b0;
  endtask

  task automatic put(input int m, input logic [31:0] a);
    mv[m] = 1'b1; maddr[m] = a; mw[m] = $urandom_range(0, 1); mwd[m] = $urandom;
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] off;
    off = 32'($urandom_range(0, 4095)) * 4;
    case ($urandom_range(0, 12))
      0:  return 32'h0800_0000 + off;
      1:  return 32'h080F_FFFC;
      2:  return 32'h2000_0000 + off;
      3:  return 32'h2001_BFFC;
      4:  return 32'h2001_C000 + off;
      5:  return 32'h2002_0000 + off;
      6:  return 32'h4002_0000 + off;
      7:  return 32'h5000_0000 + off;
      8:  return 32'h6000_0000 + off;
      9:  return 32'h1000_0000 + off;
      10: return 32'h0000_0000 + off;
      11: return 32'h4000_0000 + off;
      default: return 32'hA000_0000 + off;
    endcase
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog all: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mv = '0; mw = '0; maddr = '0; mwd = '0; tr = '0; trd = '0;
    for (int t = 0; t < NT; t++) begin g[t] = -1; p[t] = 0; end
    for (int m = 0; m < NM; m++) merr[m] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "t_valid in reset", 32'(t_valid), 32'h0);
    chk("R1", "m_ready in reset", 32'(m_ready), 32'h0);
    chk("R1", "m_err in reset",   32'(m_err),   32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1", "t_valid idle after reset", 32'(obs_tv), 32'h0);

    // All ports contend for SRAM1 straight out of reset.
    for (int m = 0; m < NM; m++) begin
      mv[m] = 1'b1; maddr[m] = 32'h2000_0100 + 32'(m) * 4; mw[m] = m[0]; mwd[m] = 32'h1111 * m;
    end
    step();
    step();
    chk("R10", "reset pointer winner valid", 32'(obs_tv[2]), 32'h1);
    chk("R10", "reset pointer winner addr", obs_taddr[2], 32'h2000_0100);
    chk("R3", "cpu data port refused sram", 32'({obs_mr[1], obs_me[1]}), 32'h3);
    step();
    step();
    chk("R7", "grant held while not ready", obs_taddr[2], 32'h2000_0100);
    tr[2] = 1'b1; trd[2] = 32'hCAFE_0001;
    step();
    chk("R6", "completion to port 0", 32'({obs_mr[0], obs_me[0]}), 32'h2);
    tr[2] = 1'b0;
    step();
    step();
    chk("R8", "next grant skips refused port", obs_taddr[2], 32'h2000_0108);
    tr[2] = 1'b1;
    repeat (30) step();
    tr = '0;

    // Parallel grants across targets; flash split.
    put(2, 32'h2001_C000); put(3, 32'h6000_0000); put(6, 32'h2002_0000);
    put(0, 32'h0800_0040); put(7, 32'h0800_0080);
    step();
    step();
    chk("R9", "five targets granted together", 32'(obs_tv & 8'b1001_1011), 32'h9B);
    chk("R11", "fetch port flash to target 0", obs_taddr[0], 32'h0800_0040);
    chk("R11", "dma flash to target 1", obs_taddr[1], 32'h0800_0080);
    tr = '1;
    repeat (4) step();
    tr = '0;

    // Refusals and decode edges.
    put(2, 32'h1000_0000); put(3, 32'h0000_1000); put(5, 32'h4002_0000);
    put(1, 32'h4002_0004); put(8, 32'h5000_0000); put(4, 32'h2001_BFFC);
    step();
    step();
    chk("R4", "ccm window refused", 32'({obs_mr[2], obs_me[2]}), 32'h3);
    chk("R4", "unmapped refused", 32'({obs_mr[3], obs_me[3]}), 32'h3);
    chk("R3", "cpu data port refused periph", 32'(obs_me[1]), 32'h1);
    chk("R3", "display dma refused periph", 32'(obs_me[8]), 32'h1);
    chk("R2", "only sram1 and periph A active", 32'(obs_tv), 32'h24);
    chk("R2", "sram1 top edge routed", obs_taddr[2], 32'h2001_BFFC);
    tr = '1;
    repeat (4) step();
    tr = '0;

    // Random traffic against the model.
    for (int c = 0; c < 4000; c++) begin
      for (int m = 0; m < NM; m++)
        if (!mv[m] && $urandom_range(0, 2) == 0) put(m, pick_addr());
      for (int t = 0; t < NT; t++) begin
        tr[t] = $urandom_range(0, 2) != 0;
        trd[t] = $urandom;
      end
      step();
    end

    summary();
    $finish;
  end

endmodule